// File: doc/BRIEF.md
# SD Data Port Block Tracker

This block sits behind the 32-bit data window of an SD host controller. Each time the processor reads or writes that window, the block moves four bytes between the register bus and a byte-wide card data channel that uses a valid/ready handshake. The bus access is held off until all four bytes have been exchanged, so the processor sees a plain word access that simply takes several cycles.

Alongside the byte movement, the block keeps track of where the transfer stands. It counts words inside a 512-byte block. It can decrement the block count held in the upper half of the block size/count register. It keeps the "read data waiting" and "write space free" status flags up to date. It also produces single-cycle events for the interrupt unit: transfer finished, data waiting and space free. When a counted multi-block transfer runs out, it starts a completion timer. When the timer expires, it reports the end of the transfer and, if enabled, asks the command unit to issue a stop command.

A new command resets the in-block position and both flags, and it abandons any completion that is still waiting on the timer. Command context (index, application-command marker, count enable, auto-stop enable) is captured when a command starts.

Top module: `sdp_data_port`

## Requirements
- R1: On a write access the four bytes of `port_wdata` are offered on `card_tx_data` in the order bits 7:0, 15:8, 23:16, 31:24. Each byte is sent on a cycle where `card_tx_valid` and `card_tx_ready` are both high.
- R2: On a read access the first byte accepted from the card lands in `port_rdata[7:0]` and the fourth lands in bits 31:24. `port_ack` stays low until four handshakes have completed, is high for exactly one cycle, and never comes sooner than 5 cycles after the request is first presented.
- R3: Every acknowledged access advances a word position. The access that completes word 128 of a block (BLK_BYTES/4) is a block boundary, and the position then returns to 0. A command start sets the position back to 0.
- R4: At a block boundary, if the captured count-enable is set, `sc_q[31:16]` decrements by one, wrapping from 0 to 0xFFFF. `sc_q[15:0]` changes only through `sc_wr`. Without count-enable the count is unchanged. A write through `sc_wr` loads all 32 bits.
- R5: When a read boundary decrements the count to zero, `data_avail` is cleared and a completion is scheduled. `ev_data_end` pulses DONE_DELAY cycles after the cycle in which that access's immediate events appear, which is one cycle after `port_ack`. A write boundary that reaches zero schedules the completion in the same way.
- R6: When a scheduled completion fires and the captured auto-stop bit is set, `stop_req` pulses in the same cycle as `ev_data_end`. During that pulse `stop_idx` is 12 and `stop_arg` is 0. Without auto-stop, `stop_req` stays low.
- R7: At a boundary, if the captured command is index 17 on a read or index 24 on a write, and the application-command marker is clear, the matching flag is cleared and `ev_data_end` pulses at once. With the marker set, this does not happen.
- R8: A read acknowledged while `card_has_data` is low clears `data_avail` and pulses `ev_data_end`, with no `ev_data_avail`.
- R9: After each read, `data_avail` is set unless R5, R7 or R8 cleared it. `ev_data_avail` pulses on every read that leaves it set.
- R10: After each write, `space_avail` is set and `ev_space_avail` pulses, unless R7 cleared it. A write leaves `data_avail` unchanged.
- R11: `cmd_start` clears both flags. It also cancels a pending completion, including one that would expire in the very cycle `cmd_start` is sampled, so no `ev_data_end` or `stop_req` follows.
- R12: After reset both flags, all events, `stop_req`, `port_ack` and `sc_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_req | input | 1 | Data-window access request, held until `port_ack` |
| port_we | input | 1 | 1 = write access, 0 = read; held with `port_req` through `port_ack` |
| port_wdata | input | 32 | Write word |
| port_rdata | output | 32 | Read word, valid while `port_ack` is high |
| port_ack | output | 1 | One-cycle access completion |
| cmd_start | input | 1 | One-cycle pulse: a new command begins |
| cmd_index | input | 6 | Command index captured at `cmd_start` |
| cmd_app | input | 1 | Command follows an application-command prefix |
| cmd_cnt_en | input | 1 | Block count decrement enable |
| cmd_auto_stop | input | 1 | Request a stop command after counted completion |
| sc_wr | input | 1 | Load block size/count register |
| sc_wdata | input | 32 | Value for `sc_wr` (count in 31:16, size in 15:0) |
| sc_q | output | 32 | Block size/count register |
| card_tx_valid | output | 1 | Byte to card valid |
| card_tx_data | output | 8 | Byte to card |
| card_tx_ready | input | 1 | Card accepts byte |
| card_rx_valid | input | 1 | Byte from card valid |
| card_rx_data | input | 8 | Byte from card |
| card_rx_ready | output | 1 | Block accepts byte |
| card_has_data | input | 1 | Card has further read data; sampled while `port_ack` is high |
| data_avail | output | 1 | Read data waiting flag |
| space_avail | output | 1 | Write space free flag |
| ev_data_end | output | 1 | Transfer-end event pulse |
| ev_data_avail | output | 1 | Data-waiting event pulse |
| ev_space_avail | output | 1 | Space-free event pulse |
| stop_req | output | 1 | Stop command request pulse |
| stop_idx | output | 6 | Stop command index, 12 during `stop_req` |
| stop_arg | output | 32 | Stop command argument, zero |

## Verification
The delicate collision is between the completion timer expiring and a new command starting in the same cycle. The cancel has to win, so neither the end event nor the stop request may appear. The bench runs a counted write block down to zero with auto-stop on. It then times `cmd_start` so that it is sampled on exactly the edge at which the delayed end event would be registered. It judges the result by requiring that no end-event or stop pulse is seen in the following window. A sibling run lets the same timer expire untouched, and both pulses must arrive in their predicted cycle. That run shows the collision case is not vacuous.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    localparam int WORD_BYTES = 4;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = WORD_BYTES * BYTE_W;
    localparam int CIDX_W     = 6;
    localparam int BIDX_W     = $clog2(WORD_BYTES);

    localparam logic [CIDX_W-1:0] CMD_STOP      = 6'd12;
    localparam logic [CIDX_W-1:0] CMD_RD_SINGLE = 6'd17;
    localparam logic [CIDX_W-1:0] CMD_WR_SINGLE = 6'd24;

    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_MOVE = 2'd1,
        LN_ACK  = 2'd2
    } lane_st_e;

    typedef struct packed {
        logic [CIDX_W-1:0] idx;
        logic              app;
        logic              cnt_en;
        logic              auto_stop;
    } cmd_ctx_t;

    typedef struct packed {
        logic avail;
        logic space;
    } flags_t;

    typedef struct packed {
        logic data_end;
        logic data_av;
        logic space_av;
    } evt_t;

    function automatic logic plain_single(cmd_ctx_t c, logic is_write);
        return !c.app && (c.idx == (is_write ? CMD_WR_SINGLE : CMD_RD_SINGLE));
    endfunction

endpackage

// File: rtl/sdp_byte_lane.sv
module sdp_byte_lane
    import sdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              done,
    output logic              done_we,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready
);

    lane_st_e          st_q;
    logic [BIDX_W-1:0] idx_q;
    logic [WORD_W-1:0] word_q;
    logic              dir_q;
    logic              hs;

    // Byte select for the current handshake position
    logic [BYTE_W-1:0] lane_bytes [WORD_BYTES];
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_split
        assign lane_bytes[g] = word_q[g*BYTE_W +: BYTE_W];
    end

    assign tx_valid = (st_q == LN_MOVE) && dir_q;
    assign rx_ready = (st_q == LN_MOVE) && !dir_q;
    assign tx_data  = lane_bytes[idx_q];
    assign hs       = dir_q ? (tx_valid && tx_ready) : (rx_valid && rx_ready);
    assign done     = (st_q == LN_ACK);
    assign done_we  = dir_q;
    assign rdata    = word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LN_IDLE;
            idx_q  <= '0;
            word_q <= '0;
            dir_q  <= 1'b0;
        end else begin
            unique case (st_q)
                LN_IDLE: begin
                    if (req) begin
                        word_q <= wdata;
                        dir_q  <= we;
                        idx_q  <= '0;
                        st_q   <= LN_MOVE;
                    end
                end
                LN_MOVE: begin
                    if (hs) begin
                        if (!dir_q) begin
                            word_q[{idx_q, 3'b000} +: BYTE_W] <= rx_data;
                        end
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == BIDX_W'(WORD_BYTES - 1)) begin
                            st_q <= LN_ACK;
                        end
                    end
                end
                default: st_q <= LN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdp_blk_track.sv
module sdp_blk_track
    import sdp_pkg::*;
#(
    parameter int WORDS_PER_BLK = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              clear,
    input  logic              cnt_en,
    input  logic              sc_wr,
    input  logic [WORD_W-1:0] sc_wdata,
    output logic [WORD_W-1:0] sc_q,
    output logic              boundary,
    output logic              zero_hit
);

    localparam int WCW   = (WORDS_PER_BLK > 1) ? $clog2(WORDS_PER_BLK) : 1;
    localparam int HALF  = WORD_W / 2;

    logic [WCW-1:0]  wcnt_q;
    logic [HALF-1:0] cnt_next;
    logic            dec;

    assign boundary = step && (wcnt_q == WCW'(WORDS_PER_BLK - 1));
    assign dec      = boundary && cnt_en;
    assign cnt_next = sc_q[WORD_W-1:HALF] - 1'b1;
    assign zero_hit = dec && (cnt_next == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q <= '0;
        end else if (clear) begin
            wcnt_q <= '0;
        end else if (step) begin
            wcnt_q <= boundary ? '0 : wcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_q <= '0;
        end else if (sc_wr) begin
            sc_q <= sc_wdata;
        end else if (dec) begin
            sc_q[WORD_W-1:HALF] <= cnt_next;
        end
    end

endmodule

// File: rtl/sdp_done_timer.sv
module sdp_done_timer #(
    parameter int DELAY = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic cancel,
    output logic fire
);

    localparam int CW = $clog2(DELAY + 2);

    logic          active_q;
    logic [CW-1:0] cnt_q;

    if (DELAY == 0) begin : g_direct
        assign fire = load && !cancel;
    end else begin : g_count
        assign fire = active_q && (cnt_q == CW'(1)) && !cancel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (cancel) begin
            active_q <= 1'b0;
        end else if (load && (DELAY != 0)) begin
            active_q <= 1'b1;
            cnt_q    <= CW'(DELAY);
        end else if (active_q) begin
            if (cnt_q == CW'(1)) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdp_data_port.sv
module sdp_data_port
    import sdp_pkg::*;
#(
    parameter int BLK_BYTES  = 512,
    parameter int DONE_DELAY = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        port_req,
    input  logic        port_we,
    input  logic [31:0] port_wdata,
    output logic [31:0] port_rdata,
    output logic        port_ack,
    input  logic        cmd_start,
    input  logic [5:0]  cmd_index,
    input  logic        cmd_app,
    input  logic        cmd_cnt_en,
    input  logic        cmd_auto_stop,
    input  logic        sc_wr,
    input  logic [31:0] sc_wdata,
    output logic [31:0] sc_q,
    output logic        card_tx_valid,
    output logic [7:0]  card_tx_data,
    input  logic        card_tx_ready,
    input  logic        card_rx_valid,
    input  logic [7:0]  card_rx_data,
    output logic        card_rx_ready,
    input  logic        card_has_data,
    output logic        data_avail,
    output logic        space_avail,
    output logic        ev_data_end,
    output logic        ev_data_avail,
    output logic        ev_space_avail,
    output logic        stop_req,
    output logic [5:0]  stop_idx,
    output logic [31:0] stop_arg
);

    localparam int WORDS_PER_BLK = BLK_BYTES / WORD_BYTES;

    logic     done, done_we;
    logic     boundary, zero_hit;
    logic     tmr_load, fire;
    cmd_ctx_t ctx_q;
    flags_t   flags_q, flags_d;
    evt_t     evt_q, evt_d;
    logic     stop_q;

    sdp_byte_lane u_lane (
        .clk      (clk),
        .rst      (rst),
        .req      (port_req),
        .we       (port_we),
        .wdata    (port_wdata),
        .rdata    (port_rdata),
        .done     (done),
        .done_we  (done_we),
        .tx_valid (card_tx_valid),
        .tx_data  (card_tx_data),
        .tx_ready (card_tx_ready),
        .rx_valid (card_rx_valid),
        .rx_data  (card_rx_data),
        .rx_ready (card_rx_ready)
    );

    sdp_blk_track #(.WORDS_PER_BLK(WORDS_PER_BLK)) u_track (
        .clk      (clk),
        .rst      (rst),
        .step     (done),
        .clear    (cmd_start),
        .cnt_en   (ctx_q.cnt_en),
        .sc_wr    (sc_wr),
        .sc_wdata (sc_wdata),
        .sc_q     (sc_q),
        .boundary (boundary),
        .zero_hit (zero_hit)
    );

    sdp_done_timer #(.DELAY(DONE_DELAY)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .cancel (cmd_start),
        .fire   (fire)
    );

    // Flag and event resolution for one completed access
    always_comb begin
        flags_d  = flags_q;
        evt_d    = '0;
        tmr_load = 1'b0;
        if (done) begin
            if (!done_we) begin
                flags_d.avail = 1'b1;
                if (zero_hit) begin
                    flags_d.avail = 1'b0;
                    tmr_load      = 1'b1;
                end
                if (boundary && plain_single(ctx_q, 1'b0)) begin
                    flags_d.avail  = 1'b0;
                    evt_d.data_end = 1'b1;
                end
                if (!card_has_data) begin
                    flags_d.avail  = 1'b0;
                    evt_d.data_end = 1'b1;
                end
                evt_d.data_av = flags_d.avail;
            end else begin
                flags_d.space = 1'b1;
                if (zero_hit) begin
                    tmr_load = 1'b1;
                end
                if (boundary && plain_single(ctx_q, 1'b1)) begin
                    flags_d.space  = 1'b0;
                    evt_d.data_end = 1'b1;
                end
                evt_d.space_av = flags_d.space;
            end
        end
        if (cmd_start) begin
            flags_d = '0;
        end
        if (fire) begin
            evt_d.data_end = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            evt_q   <= '0;
            stop_q  <= 1'b0;
            ctx_q   <= '0;
        end else begin
            flags_q <= flags_d;
            evt_q   <= evt_d;
            stop_q  <= fire && ctx_q.auto_stop;
            if (cmd_start) begin
                ctx_q <= '{idx: cmd_index, app: cmd_app,
                           cnt_en: cmd_cnt_en, auto_stop: cmd_auto_stop};
            end
        end
    end

    assign port_ack       = done;
    assign data_avail     = flags_q.avail;
    assign space_avail    = flags_q.space;
    assign ev_data_end    = evt_q.data_end;
    assign ev_data_avail  = evt_q.data_av;
    assign ev_space_avail = evt_q.space_av;
    assign stop_req       = stop_q;
    assign stop_idx       = stop_q ? CMD_STOP : '0;
    assign stop_arg       = '0;

endmodule

// File: rtl/sdp_data_port_chk.sv
module sdp_data_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        port_we,
    input logic        port_ack,
    input logic        cmd_start,
    input logic        sc_wr,
    input logic [31:0] sc_q,
    input logic        card_has_data,
    input logic        data_avail,
    input logic        space_avail,
    input logic        ev_data_end,
    input logic        stop_req,
    input logic [5:0]  stop_idx
);

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        port_ack |=> !port_ack);

    // R8
    no_more_data_chk: assert property (@(posedge clk) disable iff (rst)
        (port_ack && !port_we && !card_has_data && !cmd_start)
        |=> (ev_data_end && !data_avail));

    // R11
    cmd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> (!data_avail && !space_avail));

    // R6
    stop_pair_chk: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> (ev_data_end && stop_idx == 6'd12));

    // R4
    size_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sc_wr |=> $stable(sc_q[15:0]));

    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sc_wr && !port_ack) |=> $stable(sc_q[31:16]));

    // R10
    wr_keeps_avail_chk: assert property (@(posedge clk) disable iff (rst)
        (port_ack && port_we && !cmd_start) |=> $stable(data_avail));

endmodule

bind sdp_data_port sdp_data_port_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .port_we       (port_we),
    .port_ack      (port_ack),
    .cmd_start     (cmd_start),
    .sc_wr         (sc_wr),
    .sc_q          (sc_q),
    .card_has_data (card_has_data),
    .data_avail    (data_avail),
    .space_avail   (space_avail),
    .ev_data_end   (ev_data_end),
    .stop_req      (stop_req),
    .stop_idx      (stop_idx)
);

// File: tb/sdp_data_port_tb_top.sv
module sdp_data_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 20;
    localparam int WPB        = 128;

    typedef enum int {K_DE, K_DA, K_SA, K_ST} kind_e;
    typedef struct {
        kind_e kind;
        int    cyc;
        bit    dly;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_req = 1'b0, port_we = 1'b0;
    logic [31:0] port_wdata = '0, port_rdata;
    logic        port_ack;
    logic        cmd_start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic        cmd_app = 1'b0, cmd_cnt_en = 1'b0, cmd_auto_stop = 1'b0;
    logic        sc_wr = 1'b0;
    logic [31:0] sc_wdata = '0, sc_q;
    logic        card_tx_valid, card_tx_ready;
    logic [7:0]  card_tx_data;
    logic        card_rx_valid, card_rx_ready;
    logic [7:0]  card_rx_data;
    logic        card_has_data = 1'b1;
    logic        data_avail, space_avail;
    logic        ev_data_end, ev_data_avail, ev_space_avail;
    logic        stop_req;
    logic [5:0]  stop_idx;
    logic [31:0] stop_arg;

    int   n_chk = 0, n_fail = 0, cyc = 0, n_de_seen = 0;
    bit   slow = 1'b0, tgl = 1'b0, finished = 1'b0;
    logic [7:0] rx_byte = 8'h10;
    logic [7:0] txq[$];
    exp_t expq[$];

    // bench-side model of the requirements
    int m_wc = 0, m_cnt = 0, m_lo = 0;
    bit m_en = 0, m_auto = 0, m_app = 0, m_av = 0, m_sp = 0;
    int m_idx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdp_data_port #(.BLK_BYTES(512), .DONE_DELAY(DLY)) dut_i (.*);

    // card model
    assign card_tx_ready = slow ? tgl : 1'b1;
    assign card_rx_valid = slow ? tgl : 1'b1;
    assign card_rx_data  = rx_byte;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tgl <= ~tgl;
        if (card_tx_valid && card_tx_ready) txq.push_back(card_tx_data);
        if (card_rx_valid && card_rx_ready) rx_byte <= rx_byte + 8'd1;
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic bit take(kind_e k, int c);
        for (int i = 0; i < expq.size(); i++) begin
            if (expq[i].kind == k && expq[i].cyc == c) begin
                expq.delete(i);
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (ev_data_end) begin
                n_de_seen++;
                chk(take(K_DE, cyc), "R5/R7/R8 data-end pulse expected", 32'd1, 32'd0);
            end
            if (ev_data_avail)
                chk(take(K_DA, cyc), "R9 data-avail pulse expected", 32'd1, 32'd0);
            if (ev_space_avail)
                chk(take(K_SA, cyc), "R10 space-avail pulse expected", 32'd1, 32'd0);
            if (stop_req) begin
                chk(take(K_ST, cyc), "R6 stop request expected", 32'd1, 32'd0);
                chk(stop_idx == 6'd12 && stop_arg == 32'd0, "R6 stop index/arg",
                    {stop_idx, stop_arg[25:0]}, {6'd12, 26'd0});
            end
        end
    end

    task automatic push_exp(kind_e k, int c, bit d);
        exp_t e;
        e.kind = k; e.cyc = c; e.dly = d;
        expq.push_back(e);
    endtask

    // caller is at a negedge
    task automatic do_cmd(int idx, bit app, bit en, bit autos);
        int c = cyc;
        cmd_index = 6'(idx); cmd_app = app; cmd_cnt_en = en; cmd_auto_stop = autos;
        cmd_start = 1'b1;
        for (int i = expq.size() - 1; i >= 0; i--)
            if (expq[i].dly && expq[i].cyc >= c + 1) expq.delete(i);
        m_idx = idx; m_app = app; m_en = en; m_auto = autos;
        m_wc = 0; m_av = 0; m_sp = 0;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(!data_avail && !space_avail, "R11 flags after command",
            {30'd0, data_avail, space_avail}, 32'd0);
    endtask

    task automatic load_sc(logic [31:0] v);
        sc_wr = 1'b1; sc_wdata = v;
        @(negedge clk);
        sc_wr = 1'b0;
        m_cnt = int'(v[31:16]); m_lo = int'(v[15:0]);
        chk(sc_q == v, "R4 size/count load", sc_q, v);
    endtask

    task automatic access(bit we, logic [31:0] wd, bit hd, output int ack_cyc);
        int s;
        logic [7:0] b0;
        logic [31:0] rd, expw;
        bit bnd, zero, de, av, sp;
        card_has_data = hd;
        b0 = rx_byte;
        txq.delete();
        port_req = 1'b1; port_we = we; port_wdata = wd;
        s = cyc;
        do @(negedge clk); while (!port_ack);
        ack_cyc = cyc;
        rd = port_rdata;
        port_req = 1'b0;
        chk(ack_cyc - s >= 5, "R2 access stalled until four handshakes",
            32'(ack_cyc - s), 32'd5);
        // model
        bnd = (m_wc == WPB - 1);
        m_wc = bnd ? 0 : m_wc + 1;
        zero = 1'b0;
        if (bnd && m_en) begin
            m_cnt = (m_cnt - 1) & 16'hffff;
            zero = (m_cnt == 0);
        end
        de = 1'b0;
        if (!we) begin
            av = 1'b1;
            if (zero) av = 1'b0;
            if (bnd && !m_app && m_idx == 17) begin av = 1'b0; de = 1'b1; end
            if (!hd) begin av = 1'b0; de = 1'b1; end
            m_av = av;
            if (av) push_exp(K_DA, ack_cyc + 1, 1'b0);
        end else begin
            sp = 1'b1;
            if (bnd && !m_app && m_idx == 24) begin sp = 1'b0; de = 1'b1; end
            m_sp = sp;
            if (sp) push_exp(K_SA, ack_cyc + 1, 1'b0);
        end
        if (de) push_exp(K_DE, ack_cyc + 1, 1'b0);
        if (zero) begin
            push_exp(K_DE, ack_cyc + 1 + DLY, 1'b1);
            if (m_auto) push_exp(K_ST, ack_cyc + 1 + DLY, 1'b1);
        end
        @(negedge clk);
        chk(data_avail == m_av, "R5/R7/R8/R9 data_avail flag", 32'(data_avail), 32'(m_av));
        chk(space_avail == m_sp, "R7/R10 space_avail flag", 32'(space_avail), 32'(m_sp));
        chk(sc_q == {16'(m_cnt), 16'(m_lo)}, "R3/R4 size/count after access",
            sc_q, {16'(m_cnt), 16'(m_lo)});
        if (we) begin
            expw = {txq.size() > 3 ? txq[3] : 8'hxx, txq.size() > 2 ? txq[2] : 8'hxx,
                    txq.size() > 1 ? txq[1] : 8'hxx, txq.size() > 0 ? txq[0] : 8'hxx};
            chk(txq.size() == 4 && expw == wd, "R1 write byte order", expw, wd);
        end else begin
            expw = {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0};
            chk(rd == expw, "R2 read byte packing", rd, expw);
        end
    endtask

    task automatic run(bit we, int n, bit hd, output int last);
        last = 0;
        for (int i = 0; i < n; i++)
            access(we, 32'hA5000000 ^ (32'(i) * 32'h01030507), hd, last);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        if (finished) return;
        foreach (expq[i]) begin
            n_chk++; n_fail++;
            $display("FAIL R5/R6/R7/R9/R10 missing event kind=%0d actual=absent expected=cycle %0d",
                     expq[i].kind, expq[i].cyc);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        int last, de0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk({data_avail, space_avail, ev_data_end, ev_data_avail, ev_space_avail,
             stop_req, port_ack} == 7'd0, "R12 outputs after reset",
            {25'd0, data_avail, space_avail, ev_data_end, ev_data_avail,
             ev_space_avail, stop_req, port_ack}, 32'd0);
        chk(sc_q == 32'd0, "R12 size/count after reset", sc_q, 32'd0);

        // R1 R10: plain writes, fast then slow card
        do_cmd(25, 0, 0, 0);
        run(1'b1, 3, 1'b1, last);
        slow = 1'b1;
        run(1'b1, 2, 1'b1, last);
        // R2 R9: reads with slow card
        do_cmd(18, 0, 0, 0);
        run(1'b0, 3, 1'b1, last);
        slow = 1'b0;
        // R8: card runs dry
        access(1'b0, 32'd0, 1'b0, last);
        run(1'b0, 1, 1'b1, last);

        // R4 R5 R6: counted read of two blocks with auto-stop
        load_sc(32'h0002_0200);
        do_cmd(18, 0, 1, 1);
        run(1'b0, 2 * WPB, 1'b1, last);
        wait_n(DLY + 3);
        chk(!data_avail, "R5 data_avail clear after count hits zero", 32'(data_avail), 32'd0);

        // R4: no decrement without count enable
        load_sc(32'h0003_0040);
        do_cmd(18, 0, 0, 0);
        run(1'b0, WPB, 1'b1, last);

        // R7: application-prefixed index 17 is not single-block
        do_cmd(17, 1, 0, 0);
        run(1'b0, WPB, 1'b1, last);
        // R3 R7: partial block, then new command restarts word position
        do_cmd(18, 0, 0, 0);
        run(1'b0, 5, 1'b1, last);
        do_cmd(17, 0, 0, 0);
        run(1'b0, WPB, 1'b1, last);
        // R7 R10: single write
        do_cmd(24, 0, 0, 0);
        run(1'b1, WPB, 1'b1, last);

        // R5 R11: counted write, cancelled early
        load_sc(32'h0001_0200);
        do_cmd(25, 0, 1, 1);
        run(1'b1, WPB, 1'b1, last);
        de0 = n_de_seen;
        do_cmd(25, 0, 0, 0);
        wait_n(DLY + 5);
        chk(n_de_seen == de0, "R11 early cancel suppresses data end",
            32'(n_de_seen - de0), 32'd0);

        // R11: cancel in the exact expiry cycle
        load_sc(32'h0001_0200);
        do_cmd(25, 0, 1, 1);
        run(1'b1, WPB, 1'b1, last);
        de0 = n_de_seen;
        wait_n(DLY - 1);
        chk(cyc == last + DLY, "R11 collision alignment", 32'(cyc), 32'(last + DLY));
        do_cmd(25, 0, 0, 0);
        wait_n(DLY + 5);
        chk(n_de_seen == de0, "R11 same-cycle cancel suppresses data end",
            32'(n_de_seen - de0), 32'd0);

        // R4: count wraps from zero, no completion scheduled
        load_sc(32'h0000_0200);
        do_cmd(25, 0, 1, 1);
        run(1'b1, WPB, 1'b1, last);
        chk(sc_q == 32'hFFFF_0200, "R4 count wrap", sc_q, 32'hFFFF_0200);
        wait_n(DLY + 5);
        finish_up();
    end

endmodule